// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one 16-bit channel that sits beside a shared timer counter. It has two modes. In output mode it holds a compare value and drives a level on its output line. The line is high while the counter is below the active compare value and low otherwise. Software writes the compare value through a small register port. A preload bit decides when a write takes effect. With preload off, the write reaches the active compare register at once. With preload on, the write waits in a holding register until the time-base raises its update pulse.

In input mode the same register works as a capture latch. The capture input is passed through a two-flop synchronizer. On each rising edge of the synchronized input, the register latches the counter value. A capture flag tells software that a new value is waiting. An overcapture flag tells software that a value was overwritten before it was read. Reading the register clears both flags. Software writes are dropped in this mode.

Top module: `cc_chan`

## Requirements
- R1: After reset the register reads 0x0000, and `cap_flag_o`, `ovr_flag_o` and `oc_o` are all 0.
- R2: In output mode (`mode_i`=0) with `pre_en_i`=0, a write reaches the active compare value at the next clock edge. Comparisons use it from the following cycle.
- R3: In output mode with `pre_en_i`=1, a write is held and the active compare value does not change until a cycle with `upd_i`=1. If the write and the update fall in the same cycle, the newly written value is the one transferred. `rd_data_o` returns the written value straight away, even before the transfer.
- R4: In output mode, `oc_o` is 1 exactly when `cnt_i` is below the active compare value. In input mode (`mode_i`=1), `oc_o` is 0.
- R5: In input mode, `cap_i` passes through two synchronizing flops. A rising edge that is first sampled at clock edge k latches `cnt_i` into the register at clock edge k+2.
- R6: In input mode, `wr_en_i` has no effect on the register.
- R7: A capture sets `cap_flag_o`. A cycle with `rd_en_i`=1 and no capture clears it.
- R8: A capture while `cap_flag_o`=1 sets `ovr_flag_o`. A read with no capture in the same cycle clears it.
- R9: A falling edge on `cap_i`, or `cap_i` held high, causes no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 16 | Shared timer count |
| upd_i | input | 1 | Update pulse from the time-base |
| mode_i | input | 1 | 0 = output compare, 1 = input capture |
| pre_en_i | input | 1 | Preload enable for compare writes |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Register write data |
| rd_en_i | input | 1 | Register read strobe; clears the flags |
| rd_data_o | output | 16 | Register contents |
| cap_i | input | 1 | Asynchronous capture input |
| oc_o | output | 1 | Output-compare level |
| cap_flag_o | output | 1 | Capture pending |
| ovr_flag_o | output | 1 | Overcapture |

## Verification
A stale or wrongly loaded active compare value shows up on `oc_o` in the first cycle after the write or update. To expose it, the bench places `cnt_i` on each side of the expected threshold. A synchronizer with the wrong depth shifts the capture by a cycle. The bench catches this by reading the register one edge before and at the expected capture edge. Flag state is checked right after each capture and read, and a leaked write or a spurious capture is visible on `rd_data_o` in the very next cycle.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic {
    CC_OUT = 1'b0,
    CC_IN  = 1'b1
  } cc_mode_e;
endpackage

// File: rtl/cc_edge_sync.sv
module cc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], a_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  AST_SYNC_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> $past(a_i, 2)) else $error("sync delay"); // R5
endmodule

// File: rtl/cc_ccr_regs.sv
module cc_ccr_regs
  import cc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cc_mode_e     mode_i,
  input  logic         pre_en_i,
  input  logic         upd_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_en_i,
  input  logic         cap_ev_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] ccr_o,
  output logic [W-1:0] act_o,
  output logic         cap_flag_o,
  output logic         ovr_flag_o
);
  logic [W-1:0] ccr_q, act_q;
  logic         flag_q, ovr_q;
  logic         out_mode, cap_ev;

  assign out_mode = (mode_i == CC_OUT);
  assign cap_ev   = cap_ev_i & ~out_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ccr_q <= '0;
      act_q <= '0;
    end else if (out_mode) begin
      if (wr_en_i) ccr_q <= wr_data_i;
      if (!pre_en_i && wr_en_i) act_q <= wr_data_i;
      else if (pre_en_i && upd_i) act_q <= wr_en_i ? wr_data_i : ccr_q;
    end else if (cap_ev) begin
      ccr_q <= cnt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (cap_ev) begin
      flag_q <= 1'b1;
      if (flag_q) ovr_q <= 1'b1;
    end else if (rd_en_i) begin
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
    end
  end

  assign ccr_o      = ccr_q;
  assign act_o      = act_q;
  assign cap_flag_o = flag_q;
  assign ovr_flag_o = ovr_q;

  AST_DIRECT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_mode && !pre_en_i && wr_en_i) |=> act_q == $past(wr_data_i)) else $error("direct"); // R2
  AST_PRE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_mode && pre_en_i && !upd_i) |=> $stable(act_q)) else $error("hold"); // R3
  AST_CAP_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_ev |=> ccr_q == $past(cnt_i)) else $error("latch"); // R5
  AST_IN_WR_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_mode && !cap_ev) |=> $stable(ccr_q)) else $error("wr ign"); // R6
  AST_FLAG_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !cap_ev) |=> !flag_q && !ovr_q) else $error("clr"); // R7
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_ev && flag_q) |=> ovr_q) else $error("ovr"); // R8
endmodule

// File: rtl/cc_cmp_out.sv
module cc_cmp_out
  import cc_pkg::*;
#(
  parameter int W = 16
) (
  input  cc_mode_e     mode_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] act_i,
  output logic         oc_o
);
  always_comb begin
    oc_o = 1'b0;
    if (mode_i == CC_OUT) oc_o = (cnt_i < act_i);
  end

  always_comb begin
    if (mode_i == CC_IN) AST_OC_IN_LOW: assert (!oc_o); // R4
  end
endmodule

// File: rtl/cc_chan.sv
module cc_chan
  import cc_pkg::*;
#(
  parameter int W        = 16,
  parameter int SYNC_STG = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cnt_i,
  input  logic         upd_i,
  input  logic         mode_i,
  input  logic         pre_en_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_en_i,
  output logic [W-1:0] rd_data_o,
  input  logic         cap_i,
  output logic         oc_o,
  output logic         cap_flag_o,
  output logic         ovr_flag_o
);
  cc_mode_e     mode;
  logic         rise;
  logic [W-1:0] act;

  assign mode = cc_mode_e'(mode_i);

  cc_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .a_i   (cap_i),
    .rise_o(rise)
  );

  cc_ccr_regs #(.W(W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .pre_en_i  (pre_en_i),
    .upd_i     (upd_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en_i),
    .cap_ev_i  (rise),
    .cnt_i     (cnt_i),
    .ccr_o     (rd_data_o),
    .act_o     (act),
    .cap_flag_o(cap_flag_o),
    .ovr_flag_o(ovr_flag_o)
  );

  cc_cmp_out #(.W(W)) u_cmp (
    .mode_i(mode),
    .cnt_i (cnt_i),
    .act_i (act),
    .oc_o  (oc_o)
  );
endmodule

// File: tb/sim_cc_chan.sv
module sim_cc_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = '0;
  logic        upd = 1'b0, mode = 1'b0, pre = 1'b0, wr = 1'b0, rd = 1'b0, cap = 1'b0;
  logic [15:0] wdat = '0;
  logic [15:0] rdat;
  logic        oc, cflag, oflag;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  cc_chan u0 (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .upd_i(upd), .mode_i(mode),
    .pre_en_i(pre), .wr_en_i(wr), .wr_data_i(wdat), .rd_en_i(rd),
    .rd_data_o(rdat), .cap_i(cap), .oc_o(oc), .cap_flag_o(cflag), .ovr_flag_o(oflag)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic oc_at(string req, logic [15:0] c, logic e);
    cnt = c; #1;
    chk(req, {15'd0, oc}, {15'd0, e});
  endtask

  task automatic t_reset();
    chk("R1 rd", rdat, 16'h0000);
    chk("R1 cflag", {15'd0, cflag}, 16'd0);
    chk("R1 oflag", {15'd0, oflag}, 16'd0);
    oc_at("R1 oc", 16'd0, 1'b0);
  endtask

  task automatic t_direct();
    mode = 0; pre = 0; wr = 1; wdat = 16'd100; step(); wr = 0;
    oc_at("R2 below", 16'd99, 1'b1);
    oc_at("R4 equal", 16'd100, 1'b0);
    oc_at("R4 above", 16'd500, 1'b0);
  endtask

  task automatic t_preload();
    pre = 1; wr = 1; wdat = 16'd50; step(); wr = 0;
    chk("R3 rd early", rdat, 16'd50);
    oc_at("R3 held", 16'd70, 1'b1);
    step();
    oc_at("R3 still held", 16'd70, 1'b1);
    upd = 1; step(); upd = 0;
    oc_at("R3 after upd", 16'd70, 1'b0);
    oc_at("R3 new below", 16'd49, 1'b1);
    wr = 1; upd = 1; wdat = 16'd200; step(); wr = 0; upd = 0;
    oc_at("R3 same cycle", 16'd150, 1'b1);
  endtask

  task automatic t_capture();
    mode = 1; pre = 0;
    oc_at("R4 input low", 16'd0, 1'b0);
    cnt = 16'd1234; cap = 1;
    step(); step();
    chk("R5 not yet", rdat, 16'd200);
    step();
    chk("R5 latched", rdat, 16'd1234);
    chk("R7 flag set", {15'd0, cflag}, 16'd1);
    chk("R8 no ovr", {15'd0, oflag}, 16'd0);
    cnt = 16'd77; repeat (3) step();
    chk("R9 held high", rdat, 16'd1234);
    cap = 0; repeat (4) step();
    chk("R9 falling", rdat, 16'd1234);
  endtask

  task automatic t_ovr_and_write();
    cnt = 16'd555; cap = 1; repeat (3) step(); cap = 0;
    chk("R8 ovr set", {15'd0, oflag}, 16'd1);
    chk("R5 second", rdat, 16'd555);
    wr = 1; wdat = 16'd999; step(); wr = 0;
    chk("R6 write ignored", rdat, 16'd555);
    rd = 1; step(); rd = 0;
    chk("R7 flag clr", {15'd0, cflag}, 16'd0);
    chk("R8 ovr clr", {15'd0, oflag}, 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #10;
    t_reset();
    @(negedge clk); rst_n = 1; step();
    t_direct();
    t_preload();
    t_capture();
    t_ovr_and_write();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule